// File: doc/BRIEF.md
# Privilege-Gated Register Access Filter

This block guards a small peripheral register file against accesses made at the wrong privilege level. Each cycle it looks at one bus request (read strobe, write strobe, address, write data) together with a privilege input that says whether the requester runs at supervisor or user level. It then decides whether the register file answers. A permitted access is acknowledged one cycle later, and a read returns data in that same cycle. A refused access gets no acknowledge and changes no register. Instead a one-cycle pass-external pulse tells the bus fabric to route the transaction onward to the external bus.

The configuration register and the test register can only be reached at supervisor level. Every other register follows a supervisor-only bit held in the configuration register. When that bit is set, all registers need supervisor level. When it is clear, user-level code may also reach the general registers. The bit comes out of reset set, so the block starts in its most restrictive state. The bit is also driven on an output, so neighbouring logic can see the current protection mode.

Top module: `prv_access_filter`

## Requirements
- R1: After reset, ack_o and pass_ext_o are low, supv_only_o is 1, the configuration register reads 0x0001, and every other register reads 0.
- R2: Address 0 is the configuration register and its bit 0 is the supervisor-only bit. Address 1 is the test register. Addresses 2 to 5 are general registers. Every register stores all 16 written bits.
- R3: An access to address 0 or 1 is permitted only when priv_sup_i is 1, whatever the value of the supervisor-only bit.
- R4: While the supervisor-only bit is 1, a user-level access (priv_sup_i = 0) to any address is refused.
- R5: While the supervisor-only bit is 0, a user-level access to a general register (addresses 2 to 5) is permitted.
- R6: In the cycle after a permitted strobe, ack_o is high for exactly one cycle. For a read, rdata_o carries the register contents as they were at the strobe.
- R7: In the cycle after a refused strobe, pass_ext_o pulses high for one cycle and ack_o stays low. A refused write leaves every register unchanged.
- R8: An access to an unmapped address (6 to 15) is refused at either privilege level.
- R9: rdata_o is 0 whenever ack_o is low and after an acknowledged write-only access.
- R10: When rd_i and wr_i are both high in a permitted access, the write takes effect and rdata_o returns the value held before the write.
- R11: A change to the supervisor-only bit applies to the first access strobed after the write that made it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 4 | Register address |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 16 | Write data |
| priv_sup_i | input | 1 | 1 = supervisor level, 0 = user level |
| supv_only_o | output | 1 | Current supervisor-only bit |
| rdata_o | output | 16 | Read data, valid with ack_o |
| ack_o | output | 1 | Access acknowledged, one cycle after the strobe |
| pass_ext_o | output | 1 | Access refused, forward to external bus |

## Verification
Two functions can meet in one cycle: a write landing in a register and a read of that same register. This happens when both strobes are raised together, and also when a write that changes the supervisor-only bit is followed at once by a user access. The random stimulus raises both strobes together on a quarter of its transactions, and directed cases clear and set the protection bit just before user accesses. A bench model judges the results: the read must return the old contents, and the permission decision must use the bit value in force at the moment of the strobe.

// File: rtl/prv_pkg.sv
package prv_pkg;
  localparam int unsigned CFG_IDX  = 0;
  localparam int unsigned TEST_IDX = 1;
  localparam int unsigned SUPV_BIT = 0;
  localparam int unsigned NUM_PROT = 2;
endpackage

// File: rtl/prv_gate.sv
module prv_gate #(
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned NUM_REGS = 6
) (
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                priv_sup_i,
  input  logic                supv_only_i,
  output logic                allowed_o,
  output logic [NUM_REGS-1:0] sel_o
);
  import prv_pkg::*;

  logic mapped, prot;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_sel
    assign sel_o[i] = (addr_i == ADDR_W'(i));
  end

  assign mapped = 32'(addr_i) < NUM_REGS;
  assign prot   = 32'(addr_i) < NUM_PROT;

  always_comb begin
    allowed_o = 1'b0;
    if (mapped) allowed_o = priv_sup_i || (!supv_only_i && !prot);
  end
endmodule

// File: rtl/prv_regfile.sv
module prv_regfile #(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned NUM_REGS = 6
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [NUM_REGS-1:0] sel_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   rdata_o,
  output logic                supv_only_o
);
  import prv_pkg::*;

  logic [DATA_W-1:0] regs [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    localparam logic [DATA_W-1:0] RST_VAL =
      (i == CFG_IDX) ? DATA_W'(1) << SUPV_BIT : '0;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                regs[i] <= RST_VAL;
      else if (we_i && sel_i[i])  regs[i] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_REGS; i++) if (sel_i[i]) rdata_o |= regs[i];
  end

  assign supv_only_o = regs[CFG_IDX][SUPV_BIT];

  // Configuration only moves on an enabled write to its slot
  assert_cfg_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && sel_i[CFG_IDX]) |=> $stable(regs[CFG_IDX]));
  assert_sel_onehot_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel_i));
endmodule

// File: rtl/prv_access_filter.sv
module prv_access_filter #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned NUM_GP = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              priv_sup_i,
  output logic              supv_only_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              ack_o,
  output logic              pass_ext_o
);
  import prv_pkg::*;
  localparam int unsigned NUM_REGS = NUM_PROT + NUM_GP;

  logic                allowed, acc, grant, deny;
  logic [NUM_REGS-1:0] sel;
  logic [DATA_W-1:0]   rf_rdata;

  prv_gate #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) u_gate (
    .addr_i     (addr_i),
    .priv_sup_i (priv_sup_i),
    .supv_only_i(supv_only_o),
    .allowed_o  (allowed),
    .sel_o      (sel)
  );

  prv_regfile #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_rf (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (grant && wr_i),
    .sel_i      (sel),
    .wdata_i    (wdata_i),
    .rdata_o    (rf_rdata),
    .supv_only_o(supv_only_o)
  );

  assign acc   = rd_i || wr_i;
  assign grant = acc && allowed;
  assign deny  = acc && !allowed;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_o      <= 1'b0;
      pass_ext_o <= 1'b0;
      rdata_o    <= '0;
    end else begin
      ack_o      <= grant;
      pass_ext_o <= deny;
      rdata_o    <= (grant && rd_i) ? rf_rdata : '0;
    end
  end

  assert_ack_pass_excl_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ack_o && pass_ext_o));
  assert_prot_user_denied_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && !priv_sup_i && (32'(addr_i) < NUM_PROT) |=> pass_ext_o && !ack_o);
  assert_supv_user_denied_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && !priv_sup_i && supv_only_o |=> pass_ext_o);
  assert_sup_ack_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && priv_sup_i && (32'(addr_i) < NUM_REGS) |=> ack_o);
  assert_unmapped_pass_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && (32'(addr_i) >= NUM_REGS) |=> pass_ext_o && !ack_o);
  assert_rdata_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack_o |-> rdata_o == '0);
  assert_idle_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc |=> !ack_o && !pass_ext_o);
endmodule

// File: tb/prv_access_filter_bench.sv
module prv_access_filter_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NREG = 6;

  logic clk = 0, rst_ni = 0;
  logic [3:0] addr_i = '0;
  logic rd_i = 0, wr_i = 0, priv_sup_i = 0;
  logic [15:0] wdata_i = '0;
  logic supv_only_o, ack_o, pass_ext_o;
  logic [15:0] rdata_o;

  int checks = 0, errors = 0;
  logic [15:0] m [NREG];

  always #(CLK_PERIOD/2) clk = ~clk;

  prv_access_filter u_prv_access_filter (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr_i), .rd_i(rd_i), .wr_i(wr_i),
    .wdata_i(wdata_i), .priv_sup_i(priv_sup_i), .supv_only_o(supv_only_o),
    .rdata_o(rdata_o), .ack_o(ack_o), .pass_ext_o(pass_ext_o)
  );

  function automatic bit allowed_f(int a, bit sup, bit supv);
    if (a >= NREG) return 0;
    if (sup) return 1;
    return !supv && a >= 2;
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic access(bit rd, bit wr, int a, logic [15:0] d, bit sup, string req);
    bit ok;
    logic [15:0] exp_rd;
    @(negedge clk);
    rd_i = rd; wr_i = wr; addr_i = 4'(a); wdata_i = d; priv_sup_i = sup;
    ok = allowed_f(a, sup, m[0][0]);
    exp_rd = (ok && rd) ? m[a] : 16'h0;
    @(negedge clk);
    rd_i = 0; wr_i = 0;
    chk(ack_o == ok, {req, " ack"}, 32'(ack_o), 32'(ok));
    chk(pass_ext_o == !ok, {req, " pass_ext"}, 32'(pass_ext_o), 32'(!ok));
    chk(rdata_o == exp_rd, {req, " rdata"}, 32'(rdata_o), 32'(exp_rd));
    if (ok && wr) m[a] = d;
    chk(supv_only_o == m[0][0], {req, " supv_only"}, 32'(supv_only_o), 32'(m[0][0]));
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    m[0] = 16'h0001;
    for (int i = 1; i < NREG; i++) m[i] = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!ack_o && !pass_ext_o, "R1 outputs", 32'({ack_o, pass_ext_o}), 0);
    chk(supv_only_o == 1'b1, "R1 supv_only", 32'(supv_only_o), 1);
    rst_ni = 1;
    for (int i = 0; i < NREG; i++) access(1, 0, i, 0, 1, "R1 reset value");
    // R4: supervisor-only set blocks user on general regs
    access(1, 0, 3, 0, 0, "R4 user read");
    access(0, 1, 4, 16'hBEEF, 0, "R4 user write");
    access(1, 0, 4, 0, 1, "R7 denied write unchanged");
    // R2: full-width storage
    access(0, 1, 2, 16'hA5C3, 1, "R2 write gp");
    access(1, 0, 2, 0, 1, "R2 read gp");
    access(0, 1, 1, 16'h7E81, 1, "R2 write test");
    access(1, 0, 1, 0, 1, "R2 read test");
    // R11: clear the supervisor-only bit, next user access passes
    access(0, 1, 0, 16'h0000, 1, "R11 clear supv");
    access(1, 0, 2, 0, 0, "R11 user read after clear");
    // R5: user write/read on general
    access(0, 1, 5, 16'h1234, 0, "R5 user write");
    access(1, 0, 5, 0, 0, "R5 user read");
    // R3: protected regs stay supervisor-only
    access(1, 0, 0, 0, 0, "R3 user read cfg");
    access(0, 1, 0, 16'h0001, 0, "R3 user write cfg");
    access(0, 1, 1, 16'hFFFF, 0, "R3 user write test");
    access(1, 0, 1, 0, 1, "R3 test unchanged");
    // R8: unmapped
    access(1, 0, 9, 0, 1, "R8 sup unmapped");
    access(0, 1, 15, 16'h55AA, 0, "R8 user unmapped");
    // R10: simultaneous read and write
    access(1, 1, 3, 16'hC0DE, 0, "R10 rd+wr");
    access(1, 0, 3, 0, 0, "R10 readback");
    // R9: write-only ack carries zero data
    access(0, 1, 4, 16'hFFFF, 1, "R9 write rdata");
    // R11: set the bit again, user access refused next
    access(0, 1, 0, 16'h0001, 1, "R11 set supv");
    access(1, 0, 4, 0, 0, "R11 user after set");
    // random mix (R6, R7)
    for (int n = 0; n < 400; n++) begin
      int k;
      k = int'($urandom % 4);
      access(k != 1, k == 1 || k == 2, int'($urandom % 16), 16'($urandom),
             1'($urandom), "R6 random");
    end
    @(negedge clk);
    chk(!ack_o && !pass_ext_o, "R6 idle", 32'({ack_o, pass_ext_o}), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule